// File: doc/BRIEF.md
# ATA Device Reset Sequencer

This block follows the reset life cycle of a single ATA disk device. It has three states: idle, held in hardware reset, or held in software reset. It watches the cable reset line and the soft-reset bit, which is sampled whenever the host writes the device control register. From these it drives the busy and ready status bits and the device's side of the bus handshake lines: I/O ready, interrupt request, DMA request, the diagnostic-pass line and the drive-active line.

When the device leaves either kind of reset, it raises a one-cycle pulse that starts diagnostics. In the same cycle it writes the fixed pass code into its error register.

On leaving hardware reset it also loads the default drive geometry. It latches what the peer device reports on the diagnostic-pass and drive-active inputs. A parameter tells the block whether it is the second device on a cable that also has a first device. That choice changes how the drive-active line behaves and how the peer inputs are read.

Top module: `ata_rst_ctrl`

## Requirements
- R1: With `rst_n` low, the block starts in the hardware-reset state. The `state_o` encoding is 2'b00 idle, 2'b01 hardware reset and 2'b10 software reset. In this state `bsy_o`=1, `drdy_o`=0, `err_o`=0, and `iordy_o`, `intrq_o`, `dmarq_o` and `pdiag_o` are all 0. `dasp_o` equals `DEV1_SHARED`.
- R2: If `hw_rst_i` is high at a clock edge and the state is not hardware reset, then after that edge the state is 2'b01. At that point `bsy_o`=1, `drdy_o`=0, `iordy_o`/`intrq_o`/`dmarq_o`/`pdiag_o`=0, and `dasp_o`=`DEV1_SHARED`.
- R3: If `hw_rst_i` is low at an edge while the state is hardware reset, then after that edge the state is 2'b00. At that point `bsy_o`=0, `drdy_o` is the inverse of `packet_i`, `err_o`=8'h01, `iordy_o`=1 and `dasp_o`=0.
- R4: On that same hardware-reset exit, `spt_o` loads `SECTORS` (default 63) and `hpc_o` loads `HEADS` (default 16). `peer_pdiag_o` and `peer_dasp_o` latch the peer inputs.
- R5: A control write (`ctl_we_i`=1) with `ctl_srst_i`=1 in the idle state enters software reset (2'b10) after the edge. It also sets `bsy_o`=1, `drdy_o`=0, `iordy_o`=0 and `pdiag_o`=0.
- R6: The following writes are ignored: a write with `ctl_srst_i`=1 while already in software reset, a write with `ctl_srst_i`=0 while idle, and any write while in hardware reset. None of them changes the state or raises `diag_start_o`.
- R7: A write with `ctl_srst_i`=0 while in software reset returns the block to idle after the edge. The outputs then match the exit values of R3, except that geometry, peer latches and `dasp_o` are left untouched.
- R8: `hw_rst_i` has priority over a control write in the same cycle. It also ends a software reset by entering hardware reset.
- R9: With `DEV1_SHARED`=1, the peer inputs are latched as 0 whatever their level, and `pdiag_o` goes to 1 on every reset exit. With `DEV1_SHARED`=0, the peer inputs are latched as driven and `pdiag_o` stays 0.
- R10: `diag_start_o` is high for exactly the one cycle after each reset exit and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| hw_rst_i | input | 1 | Cable hardware reset, active high |
| ctl_we_i | input | 1 | Device control register write strobe |
| ctl_srst_i | input | 1 | Soft-reset bit of the written control value |
| packet_i | input | 1 | Strap: device is a packet device |
| pdiag_i | input | 1 | Diagnostic-pass line from the peer device |
| dasp_i | input | 1 | Drive-active line from the peer device |
| state_o | output | 2 | Reset state (00 idle, 01 hardware, 10 software) |
| bsy_o | output | 1 | Status busy bit |
| drdy_o | output | 1 | Status device-ready bit |
| err_o | output | 8 | Error register |
| diag_start_o | output | 1 | One-cycle diagnostics start pulse |
| spt_o | output | SPT_W | Sectors per track |
| hpc_o | output | HPC_W | Heads per cylinder |
| peer_pdiag_o | output | 1 | Latched peer diagnostic-pass level |
| peer_dasp_o | output | 1 | Latched peer drive-active level |
| iordy_o | output | 1 | I/O ready |
| intrq_o | output | 1 | Interrupt request |
| dmarq_o | output | 1 | DMA request |
| pdiag_o | output | 1 | Diagnostic-pass output |
| dasp_o | output | 1 | Drive-active output |

## Verification
The bench builds two copies of the block that share one set of stimulus. One copy uses `DEV1_SHARED`=0 and the other uses `DEV1_SHARED`=1, both with the default geometry of 63 sectors and 16 heads. Holding the peer inputs high makes the difference visible: one copy latches them and the other masks them. The same stimulus also shows the drive-active line held high in hardware reset on the shared copy only, and the diagnostic-pass line raised on that copy only.

// File: rtl/ata_rst_pkg.sv
package ata_rst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_HWRST = 2'b01,
    ST_SWRST = 2'b10
  } rst_state_e;

  localparam logic [7:0] DIAG_PASS_CODE = 8'h01;

  // Ready bit after a reset: set only for non-packet devices.
  function automatic logic ready_after_reset(input logic is_packet);
    return ~is_packet;
  endfunction

  // A second device on a shared cable sees no device beyond it.
  function automatic logic peer_view(input logic shared_dev1, input logic pin);
    return shared_dev1 ? 1'b0 : pin;
  endfunction

  // Drive-active level held while hardware reset is in progress.
  function automatic logic dasp_in_reset(input logic shared_dev1);
    return shared_dev1;
  endfunction

  // Diagnostic-pass level driven once diagnostics have completed.
  function automatic logic pdiag_after_diag(input logic shared_dev1);
    return shared_dev1;
  endfunction

endpackage

// File: rtl/ata_rst_fsm.sv
module ata_rst_fsm
  import ata_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_rst_i,
  input  logic       ctl_we_i,
  input  logic       ctl_srst_i,
  output rst_state_e state_o,
  output logic       hw_enter_o,
  output logic       hw_exit_o,
  output logic       sw_enter_o,
  output logic       sw_exit_o
);

  rst_state_e st_q;
  rst_state_e st_d;

  always_comb begin
    hw_enter_o = hw_rst_i && (st_q != ST_HWRST);
    hw_exit_o  = !hw_rst_i && (st_q == ST_HWRST);
    sw_enter_o = !hw_rst_i && ctl_we_i && ctl_srst_i && (st_q == ST_IDLE);
    sw_exit_o  = !hw_rst_i && ctl_we_i && !ctl_srst_i && (st_q == ST_SWRST);
  end

  always_comb begin
    st_d = st_q;
    if (hw_enter_o)      st_d = ST_HWRST;
    else if (hw_exit_o)  st_d = ST_IDLE;
    else if (sw_enter_o) st_d = ST_SWRST;
    else if (sw_exit_o)  st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HWRST;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/ata_rst_status.sv
module ata_rst_status
  import ata_rst_pkg::*;
#(
  parameter int          SPT_W       = 8,
  parameter int          HPC_W       = 5,
  parameter int          SECTORS     = 63,
  parameter int          HEADS       = 16,
  parameter bit          DEV1_SHARED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_enter_i,
  input  logic             hw_exit_i,
  input  logic             sw_enter_i,
  input  logic             sw_exit_i,
  input  logic             packet_i,
  input  logic             pdiag_i,
  input  logic             dasp_i,
  output logic             bsy_o,
  output logic             drdy_o,
  output logic [7:0]       err_o,
  output logic             diag_start_o,
  output logic [SPT_W-1:0] spt_o,
  output logic [HPC_W-1:0] hpc_o,
  output logic             peer_pdiag_o,
  output logic             peer_dasp_o
);

  localparam logic [SPT_W-1:0] SPT_INIT = SPT_W'(SECTORS);
  localparam logic [HPC_W-1:0] HPC_INIT = HPC_W'(HEADS);

  logic any_enter;
  logic any_exit;

  assign any_enter = hw_enter_i || sw_enter_i;
  assign any_exit  = hw_exit_i  || sw_exit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_o        <= 1'b1;
      drdy_o       <= 1'b0;
      err_o        <= '0;
      diag_start_o <= 1'b0;
    end else begin
      diag_start_o <= any_exit;
      if (any_enter) begin
        bsy_o  <= 1'b1;
        drdy_o <= 1'b0;
      end else if (any_exit) begin
        bsy_o  <= 1'b0;
        drdy_o <= ready_after_reset(packet_i);
        err_o  <= DIAG_PASS_CODE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spt_o        <= '0;
      hpc_o        <= '0;
      peer_pdiag_o <= 1'b0;
      peer_dasp_o  <= 1'b0;
    end else if (hw_exit_i) begin
      spt_o        <= SPT_INIT;
      hpc_o        <= HPC_INIT;
      peer_pdiag_o <= peer_view(DEV1_SHARED, pdiag_i);
      peer_dasp_o  <= peer_view(DEV1_SHARED, dasp_i);
    end
  end

endmodule

// File: rtl/ata_rst_bus.sv
module ata_rst_bus
  import ata_rst_pkg::*;
#(
  parameter bit DEV1_SHARED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_enter_i,
  input  logic hw_exit_i,
  input  logic sw_enter_i,
  input  logic sw_exit_i,
  output logic iordy_o,
  output logic intrq_o,
  output logic dmarq_o,
  output logic pdiag_o,
  output logic dasp_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iordy_o <= 1'b0;
      intrq_o <= 1'b0;
      dmarq_o <= 1'b0;
      pdiag_o <= 1'b0;
    end else if (hw_enter_i || sw_enter_i) begin
      iordy_o <= 1'b0;
      intrq_o <= 1'b0;
      dmarq_o <= 1'b0;
      pdiag_o <= 1'b0;
    end else if (hw_exit_i || sw_exit_i) begin
      iordy_o <= 1'b1;
      pdiag_o <= pdiag_after_diag(DEV1_SHARED);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dasp_o <= dasp_in_reset(DEV1_SHARED);
    else if (hw_enter_i) dasp_o <= dasp_in_reset(DEV1_SHARED);
    else if (hw_exit_i)  dasp_o <= 1'b0;
  end

endmodule

// File: rtl/ata_rst_ctrl.sv
module ata_rst_ctrl
  import ata_rst_pkg::*;
#(
  parameter int SPT_W       = 8,
  parameter int HPC_W       = 5,
  parameter int SECTORS     = 63,
  parameter int HEADS       = 16,
  parameter bit DEV1_SHARED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst_i,
  input  logic             ctl_we_i,
  input  logic             ctl_srst_i,
  input  logic             packet_i,
  input  logic             pdiag_i,
  input  logic             dasp_i,
  output logic [1:0]       state_o,
  output logic             bsy_o,
  output logic             drdy_o,
  output logic [7:0]       err_o,
  output logic             diag_start_o,
  output logic [SPT_W-1:0] spt_o,
  output logic [HPC_W-1:0] hpc_o,
  output logic             peer_pdiag_o,
  output logic             peer_dasp_o,
  output logic             iordy_o,
  output logic             intrq_o,
  output logic             dmarq_o,
  output logic             pdiag_o,
  output logic             dasp_o
);

  rst_state_e state;
  logic       ev_hw_enter;
  logic       ev_hw_exit;
  logic       ev_sw_enter;
  logic       ev_sw_exit;

  ata_rst_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_rst_i   (hw_rst_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_srst_i (ctl_srst_i),
    .state_o    (state),
    .hw_enter_o (ev_hw_enter),
    .hw_exit_o  (ev_hw_exit),
    .sw_enter_o (ev_sw_enter),
    .sw_exit_o  (ev_sw_exit)
  );

  ata_rst_status #(
    .SPT_W       (SPT_W),
    .HPC_W       (HPC_W),
    .SECTORS     (SECTORS),
    .HEADS       (HEADS),
    .DEV1_SHARED (DEV1_SHARED)
  ) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_enter_i   (ev_hw_enter),
    .hw_exit_i    (ev_hw_exit),
    .sw_enter_i   (ev_sw_enter),
    .sw_exit_i    (ev_sw_exit),
    .packet_i     (packet_i),
    .pdiag_i      (pdiag_i),
    .dasp_i       (dasp_i),
    .bsy_o        (bsy_o),
    .drdy_o       (drdy_o),
    .err_o        (err_o),
    .diag_start_o (diag_start_o),
    .spt_o        (spt_o),
    .hpc_o        (hpc_o),
    .peer_pdiag_o (peer_pdiag_o),
    .peer_dasp_o  (peer_dasp_o)
  );

  ata_rst_bus #(
    .DEV1_SHARED (DEV1_SHARED)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_enter_i (ev_hw_enter),
    .hw_exit_i  (ev_hw_exit),
    .sw_enter_i (ev_sw_enter),
    .sw_exit_i  (ev_sw_exit),
    .iordy_o    (iordy_o),
    .intrq_o    (intrq_o),
    .dmarq_o    (dmarq_o),
    .pdiag_o    (pdiag_o),
    .dasp_o     (dasp_o)
  );

  assign state_o = state;

endmodule

// File: rtl/ata_rst_ctrl_chk.sv
module ata_rst_ctrl_chk #(
  parameter bit DEV1_SHARED = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_rst_i,
  input logic       ctl_we_i,
  input logic       ctl_srst_i,
  input logic       packet_i,
  input logic [1:0] state_o,
  input logic       bsy_o,
  input logic       drdy_o,
  input logic [7:0] err_o,
  input logic       diag_start_o,
  input logic       iordy_o,
  input logic       intrq_o,
  input logic       dmarq_o,
  input logic       pdiag_o,
  input logic       dasp_o
);

  AST_BUSY_WHILE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'b00) |-> (bsy_o && !drdy_o)); // R2

  AST_HW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rst_i && state_o != 2'b01) |=>
      (state_o == 2'b01 && bsy_o && !iordy_o && !intrq_o && !dmarq_o && !pdiag_o)); // R2

  AST_HW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_rst_i && state_o == 2'b01) |=>
      (state_o == 2'b00 && !bsy_o && err_o == 8'h01 && drdy_o == !$past(packet_i))); // R3

  AST_SW_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_rst_i && ctl_we_i && ctl_srst_i && state_o == 2'b10) |=>
      (state_o == 2'b10 && !diag_start_o)); // R6

  AST_SW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_rst_i && ctl_we_i && !ctl_srst_i && state_o == 2'b10) |=>
      (state_o == 2'b00 && diag_start_o && !bsy_o)); // R7

  AST_HW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rst_i && state_o == 2'b10) |=> (state_o == 2'b01)); // R8

  AST_DASP_IN_HW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01) |-> (dasp_o == DEV1_SHARED)); // R9

  AST_DIAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    diag_start_o |=> !diag_start_o); // R10

endmodule

bind ata_rst_ctrl ata_rst_ctrl_chk #(.DEV1_SHARED(DEV1_SHARED)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hw_rst_i     (hw_rst_i),
  .ctl_we_i     (ctl_we_i),
  .ctl_srst_i   (ctl_srst_i),
  .packet_i     (packet_i),
  .state_o      (state_o),
  .bsy_o        (bsy_o),
  .drdy_o       (drdy_o),
  .err_o        (err_o),
  .diag_start_o (diag_start_o),
  .iordy_o      (iordy_o),
  .intrq_o      (intrq_o),
  .dmarq_o      (dmarq_o),
  .pdiag_o      (pdiag_o),
  .dasp_o       (dasp_o)
);

// File: tb/ata_rst_ctrl_bench.sv
module ata_rst_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, hw_rst, we, srst, packet, pdiag_in, dasp_in;

  logic [1:0] st0, st1;
  logic bsy0, bsy1, rdy0, rdy1, dg0, dg1;
  logic [7:0] err0, err1;
  logic [7:0] spt0, spt1;
  logic [4:0] hpc0, hpc1;
  logic pp0, pp1, pd0, pd1;
  logic io0, io1, iq0, iq1, dm0, dm1, po0, po1, da0, da1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_rst_ctrl #(.DEV1_SHARED(1'b0)) u_ata_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_rst_i(hw_rst), .ctl_we_i(we), .ctl_srst_i(srst),
    .packet_i(packet), .pdiag_i(pdiag_in), .dasp_i(dasp_in),
    .state_o(st0), .bsy_o(bsy0), .drdy_o(rdy0), .err_o(err0), .diag_start_o(dg0),
    .spt_o(spt0), .hpc_o(hpc0), .peer_pdiag_o(pp0), .peer_dasp_o(pd0),
    .iordy_o(io0), .intrq_o(iq0), .dmarq_o(dm0), .pdiag_o(po0), .dasp_o(da0));

  ata_rst_ctrl #(.DEV1_SHARED(1'b1)) u_ata_rst_ctrl_d1 (
    .clk(clk), .rst_n(rst_n), .hw_rst_i(hw_rst), .ctl_we_i(we), .ctl_srst_i(srst),
    .packet_i(packet), .pdiag_i(pdiag_in), .dasp_i(dasp_in),
    .state_o(st1), .bsy_o(bsy1), .drdy_o(rdy1), .err_o(err1), .diag_start_o(dg1),
    .spt_o(spt1), .hpc_o(hpc1), .peer_pdiag_o(pp1), .peer_dasp_o(pd1),
    .iordy_o(io1), .intrq_o(iq1), .dmarq_o(dm1), .pdiag_o(po1), .dasp_o(da1));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic bit_srst);
    we = 1'b1; srst = bit_srst;
    tick();
    we = 1'b0; srst = 1'b0;
  endtask

  task automatic t_power_on();
    rst_n = 1'b0; hw_rst = 1'b1; we = 1'b0; srst = 1'b0;
    packet = 1'b0; pdiag_in = 1'b1; dasp_in = 1'b1;
    tick(); tick();
    check("R1 state",  st0, 1);
    check("R1 bsy",    bsy0, 1);
    check("R1 drdy",   rdy0, 0);
    check("R1 err",    err0, 0);
    check("R1 bus",    {io0, iq0, dm0, po0}, 0);
    check("R1 dasp d0", da0, 0);
    check("R1 dasp d1", da1, 1);
    rst_n = 1'b1;
    tick();
    check("R2 held hw", st0, 1);
  endtask

  task automatic t_hw_release();
    ctl_write(1'b1);
    check("R6 write in hw", st0, 1);
    check("R6 no diag in hw", dg0, 0);
    hw_rst = 1'b0;
    tick();
    check("R3 state",  st0, 0);
    check("R3 bsy",    bsy0, 0);
    check("R3 drdy",   rdy0, 1);
    check("R3 err",    err0, 8'h01);
    check("R3 iordy",  io0, 1);
    check("R3 dasp d1 released", da1, 0);
    check("R10 diag high", dg0, 1);
    check("R4 spt",    spt0, 63);
    check("R4 hpc",    hpc0, 16);
    check("R4 peer pdiag", pp0, 1);
    check("R4 peer dasp",  pd0, 1);
    check("R9 peer pdiag masked", pp1, 0);
    check("R9 peer dasp masked",  pd1, 0);
    check("R9 pdiag out d1", po1, 1);
    check("R9 pdiag out d0", po0, 0);
    tick();
    check("R10 diag low", dg0, 0);
  endtask

  task automatic t_idle_clear();
    ctl_write(1'b0);
    check("R6 clear while idle", st0, 0);
    check("R6 no diag idle", dg0, 0);
  endtask

  task automatic t_soft_reset();
    ctl_write(1'b1);
    check("R5 state", st0, 2);
    check("R5 bsy",   bsy0, 1);
    check("R5 drdy",  rdy0, 0);
    check("R5 iordy", io0, 0);
    check("R5 pdiag d1", po1, 0);
    ctl_write(1'b1);
    check("R6 repeat srst", st0, 2);
    check("R6 repeat no diag", dg0, 0);
    tick();
    check("R6 no write holds", st0, 2);
    ctl_write(1'b0);
    check("R7 state", st0, 0);
    check("R7 bsy",   bsy0, 0);
    check("R7 drdy",  rdy0, 1);
    check("R7 diag",  dg1, 1);
    check("R7 iordy", io1, 1);
    check("R9 pdiag after sw d1", po1, 1);
    tick();
    check("R10 diag low sw", dg1, 0);
  endtask

  task automatic t_hw_over_sw();
    ctl_write(1'b1);
    check("R8 in sw", st0, 2);
    hw_rst = 1'b1; we = 1'b1; srst = 1'b0;
    tick();
    we = 1'b0;
    check("R8 hw wins", st0, 1);
    check("R8 hw wins d1", st1, 1);
    check("R9 dasp high d1", da1, 1);
    check("R2 dasp d0", da0, 0);
    packet = 1'b1; pdiag_in = 1'b0;
    tick();
    hw_rst = 1'b0;
    tick();
    check("R3 packet drdy", rdy0, 0);
    check("R3 packet bsy",  bsy0, 0);
    check("R4 peer pdiag low", pp0, 0);
    check("R4 peer dasp", pd0, 1);
  endtask

  initial begin
    t_power_on();
    t_hw_release();
    t_idle_clear();
    t_soft_reset();
    t_hw_over_sw();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule